// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter with Abort

This block turns a block of bytes held in memory into a bit-stuffed HDLC frame on a serial line, one bit per clock. While no frame is pending it sends back-to-back flags. The host loads a start address and a user-field byte count, then writes the enable bit. The block then pulls the bytes one at a time over a request/acknowledge handshake. Each accepted byte advances the fetch address. The bytes go out least significant bit first with zero insertion, followed by a 16-bit check sequence. When the last check bit has left, the block returns to flags and raises an interrupt.

A frame stops early for one of two reasons. The host may ask for an abort, or the byte source may fail to deliver a byte before the serialiser needs it (an underrun). In both cases an abort sequence replaces the rest of the frame, the aborted status bit is set, and the interrupt rises once the abort sequence has been sent. A loopback control forces the main line to idle ones, while a second output keeps carrying the real stream. Memory access and the register decode sit outside this block.

Top module: `hdlc_tx`

## Requirements
- R1: With no frame in progress, the serial stream is the flag byte 01111110 repeated with no gap, one flag every 8 clocks.
- R2: Inside user bytes and the check sequence, a 0 bit is inserted after every run of five 1 bits. Flags and abort sequences are sent unstuffed, so a correct frame never shows six 1s in a row except within a flag.
- R3: The check sequence is the CRC with polynomial x^16+x^12+x^5+1, processed LSB first (reflected constant 0x8408), preset to 0xFFFF and sent inverted. Its low byte goes first, LSB first, as do all user bytes.
- R4: An accepted enable with a nonzero count raises byteReq. Each acknowledge captures byteData and adds one to fetchAddr. The request rises again each time a byte moves into the serialiser while more bytes remain. The frame begins at a flag boundary once the first byte is held.
- R5: If a byte is due in the serialiser and none has arrived, the block sends the abort sequence (0, seven 1s, 0), sets statAborted, and raises txIrq when the sequence ends.
- R6: An abort control write while statBusy is 1 replaces the rest of the frame with the abort sequence at the next character boundary. statAborted is then set and flags resume afterwards.
- R7: txIrq rises when the last check-sequence bit or the last abort bit has been sent. statBusy falls at the same point. txIrq stays high until an accepted transmitter reset.
- R8: A transmitter reset write clears txIrq, statAborted, fetchAddr and the stored byte count. While statBusy is 1, reset writes, enable writes and address or count writes are ignored.
- R9: While the loopback bit is set, txMain is constant 1 and txAlt carries the real stream. The loopback bit is rewritten by every control write.
- R10: An acknowledge that arrives in the very clock in which the byte is due is accepted: the byte goes straight into the serialiser and no underrun occurs.
- R11: A byte count of zero yields a frame made of only the check sequence (two 0x00 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAddrWe | input | 1 | Load fetch start address |
| cfgAddrIn | input | ADDR_W | Start address value |
| cfgLenWe | input | 1 | Load user byte count |
| cfgLenIn | input | LEN_W | Byte count value |
| ctlWe | input | 1 | Control write strobe |
| ctlEnable | input | 1 | Control: start a frame |
| ctlAbort | input | 1 | Control: abort current frame |
| ctlReset | input | 1 | Control: transmitter reset |
| ctlLoop | input | 1 | Control: loopback |
| byteReq | output | 1 | Byte wanted from source |
| byteAck | input | 1 | Source delivers byteData |
| byteData | input | 8 | Delivered byte |
| fetchAddr | output | ADDR_W | Address of next byte to fetch |
| txMain | output | 1 | Main serial output (ones in loopback) |
| txAlt | output | 1 | Secondary serial output, always the real stream |
| txIrq | output | 1 | Transmit-ended interrupt |
| statBusy | output | 1 | Status: transmitting |
| statAborted | output | 1 | Status: frame aborted |

## Verification
The close coincidence is between a byte acknowledge and the serialiser's byte boundary. These two can fall in the same clock, and that clock decides between a bypass load and an underrun abort. The bench's byte source answers after a programmable number of clocks with the request high. It sends zero bytes, so no stuffing bit moves the boundary. An 8-clock answer lands in the boundary clock and must give a clean frame. A 9-clock answer lands one clock late and must give an abort with the aborted bit set. Both outcomes are judged from the decoded line stream and the status outputs.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } txStateT;

  typedef struct packed {
    logic loadFlag;
    logic loadData;
    logic loadFcs;
    logic loadAbort;
    logic start;
    logic clear;
  } txStrobeT;

  localparam logic [7:0]  FLAG_BYTE   = 8'h7E;
  localparam logic [15:0] ABORT_BITS  = 16'h00FE;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RV = 16'h8408;

endpackage

// File: rtl/hdlc_tx_datapath.sv
module hdlc_tx_datapath
  import hdlc_tx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strobe,
  input  logic              locked,
  input  logic              cfgAddrWe,
  input  logic [ADDR_W-1:0] cfgAddrIn,
  input  logic              cfgLenWe,
  input  logic [LEN_W-1:0]  cfgLenIn,
  input  logic              byteAck,
  input  logic [7:0]        byteData,
  output logic              byteReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              txBit,
  output logic              lastBit,
  output logic              byteReady,
  output logic              bytesLeftZero
);

  localparam int SH_W   = 16;
  localparam int CNT_W  = $clog2(SH_W + 1);
  localparam int RUN_MX = 5;

  logic [SH_W-1:0]   shReg;
  logic [CNT_W-1:0]  shLeft;
  logic [2:0]        onesCnt;
  logic              curStuff;
  logic              curCrc;
  logic [15:0]       crc;
  logic [15:0]       crcNext;
  logic [7:0]        holdReg;
  logic              holdValid;
  logic              reqPend;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  lenLeft;
  logic              txReg;
  logic              stuffNow;
  logic              ackTake;
  logic              outBit;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_RV : 16'h0000);
  endfunction

  assign stuffNow      = (onesCnt == 3'(RUN_MX));
  assign outBit        = stuffNow ? 1'b0 : shReg[0];
  assign lastBit       = !stuffNow && (shLeft == CNT_W'(1));
  assign crcNext       = (curCrc && !stuffNow) ? crcStep(crc, shReg[0]) : crc;
  assign ackTake       = reqPend && byteAck;
  assign byteReady     = holdValid || ackTake;
  assign bytesLeftZero = (lenLeft == '0);

  // serialiser, zero insertion and check sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= {8'h00, FLAG_BYTE};
      shLeft   <= CNT_W'(8);
      onesCnt  <= '0;
      curStuff <= 1'b0;
      curCrc   <= 1'b0;
      crc      <= CRC_PRESET;
      txReg    <= 1'b1;
    end else begin
      txReg <= outBit;
      if (stuffNow) begin
        onesCnt <= '0;
      end else if (curStuff && shReg[0]) begin
        onesCnt <= onesCnt + 3'd1;
      end else begin
        onesCnt <= '0;
      end
      crc <= strobe.start ? CRC_PRESET : crcNext;
      if (strobe.loadFlag) begin
        shReg    <= {8'h00, FLAG_BYTE};
        shLeft   <= CNT_W'(8);
        curStuff <= 1'b0;
        curCrc   <= 1'b0;
      end else if (strobe.loadAbort) begin
        shReg    <= ABORT_BITS;
        shLeft   <= CNT_W'(9);
        curStuff <= 1'b0;
        curCrc   <= 1'b0;
      end else if (strobe.loadData) begin
        shReg    <= {8'h00, (holdValid ? holdReg : byteData)};
        shLeft   <= CNT_W'(8);
        curStuff <= 1'b1;
        curCrc   <= 1'b1;
      end else if (strobe.loadFcs) begin
        shReg    <= ~crcNext;
        shLeft   <= CNT_W'(16);
        curStuff <= 1'b1;
        curCrc   <= 1'b0;
      end else if (!stuffNow) begin
        shReg  <= shReg >> 1;
        shLeft <= shLeft - CNT_W'(1);
      end
    end
  end

  // byte fetch, address and length bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      lenReg    <= '0;
      lenLeft   <= '0;
      holdReg   <= '0;
      holdValid <= 1'b0;
      reqPend   <= 1'b0;
    end else if (strobe.clear) begin
      addrReg   <= '0;
      lenReg    <= '0;
      lenLeft   <= '0;
      holdValid <= 1'b0;
      reqPend   <= 1'b0;
    end else begin
      if (cfgAddrWe && !locked) addrReg <= cfgAddrIn;
      if (cfgLenWe && !locked)  lenReg  <= cfgLenIn;
      if (strobe.start) begin
        lenLeft   <= lenReg;
        reqPend   <= (lenReg != '0);
        holdValid <= 1'b0;
      end else begin
        if (ackTake) begin
          holdReg   <= byteData;
          holdValid <= 1'b1;
          reqPend   <= 1'b0;
          addrReg   <= addrReg + ADDR_W'(1);
        end
        if (strobe.loadData) begin
          lenLeft   <= lenLeft - LEN_W'(1);
          holdValid <= 1'b0;
          reqPend   <= (lenLeft > LEN_W'(1));
        end
        if (strobe.loadAbort) begin
          lenLeft   <= '0;
          holdValid <= 1'b0;
          reqPend   <= 1'b0;
        end
      end
    end
  end

  assign byteReq   = reqPend;
  assign fetchAddr = addrReg;
  assign txBit     = txReg;

  assert_ones_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= 3'(RUN_MX));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ackTake && !strobe.clear && !strobe.start && !(cfgAddrWe && !locked))
      |=> (fetchAddr == $past(fetchAddr) + ADDR_W'(1)));

  assert_load_boundary_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFcs || strobe.loadData || strobe.loadAbort) |-> lastBit);

endmodule

// File: rtl/hdlc_tx_control.sv
module hdlc_tx_control
  import hdlc_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctlWe,
  input  logic     ctlEnable,
  input  logic     ctlAbort,
  input  logic     ctlReset,
  input  logic     ctlLoop,
  input  logic     lastBit,
  input  logic     byteReady,
  input  logic     bytesLeftZero,
  output txStrobeT strobe,
  output logic     busy,
  output logic     aborted,
  output logic     irq,
  output logic     loopEn
);

  txStateT state, stateNext;
  logic    abortReq;
  logic    finish;
  logic    doReset;
  logic    acceptStart;

  assign doReset     = ctlWe && ctlReset && !busy;
  assign acceptStart = ctlWe && ctlEnable && !ctlReset && !busy;

  always_comb begin
    strobe       = '0;
    strobe.clear = doReset;
    strobe.start = acceptStart;
    stateNext    = state;
    finish       = 1'b0;
    if (lastBit) begin
      unique case (state)
        ST_IDLE: begin
          if (busy && abortReq) begin
            strobe.loadAbort = 1'b1;
            stateNext        = ST_ABORT;
          end else if (busy && bytesLeftZero) begin
            strobe.loadFcs = 1'b1;
            stateNext      = ST_FCS;
          end else if (busy && byteReady) begin
            strobe.loadData = 1'b1;
            stateNext       = ST_DATA;
          end else begin
            strobe.loadFlag = 1'b1;
          end
        end
        ST_DATA: begin
          if (abortReq) begin
            strobe.loadAbort = 1'b1;
            stateNext        = ST_ABORT;
          end else if (bytesLeftZero) begin
            strobe.loadFcs = 1'b1;
            stateNext      = ST_FCS;
          end else if (byteReady) begin
            strobe.loadData = 1'b1;
          end else begin
            strobe.loadAbort = 1'b1;
            stateNext        = ST_ABORT;
          end
        end
        ST_FCS: begin
          if (abortReq) begin
            strobe.loadAbort = 1'b1;
            stateNext        = ST_ABORT;
          end else begin
            strobe.loadFlag = 1'b1;
            stateNext       = ST_IDLE;
            finish          = 1'b1;
          end
        end
        ST_ABORT: begin
          strobe.loadFlag = 1'b1;
          stateNext       = ST_IDLE;
          finish          = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      aborted  <= 1'b0;
      irq      <= 1'b0;
      abortReq <= 1'b0;
      loopEn   <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctlWe) loopEn <= ctlLoop;
      if (doReset) begin
        irq     <= 1'b0;
        aborted <= 1'b0;
      end
      if (acceptStart) begin
        busy     <= 1'b1;
        abortReq <= 1'b0;
      end
      if (ctlWe && ctlAbort && busy) abortReq <= 1'b1;
      if (strobe.loadAbort) begin
        aborted  <= 1'b1;
        abortReq <= 1'b0;
      end
      if (finish) begin
        busy <= 1'b0;
        irq  <= 1'b1;
      end
    end
  end

  assert_underrun_abort_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && lastBit && !abortReq && !bytesLeftZero && !byteReady)
      |=> (aborted && state == ST_ABORT));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(ctlWe && ctlReset)) |=> irq);

  assert_busy_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(lastBit && (state == ST_FCS || state == ST_ABORT))) |=> busy);

  assert_abort_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> busy);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $fell(busy));

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgAddrWe,
  input  logic [ADDR_W-1:0] cfgAddrIn,
  input  logic              cfgLenWe,
  input  logic [LEN_W-1:0]  cfgLenIn,
  input  logic              ctlWe,
  input  logic              ctlEnable,
  input  logic              ctlAbort,
  input  logic              ctlReset,
  input  logic              ctlLoop,
  output logic              byteReq,
  input  logic              byteAck,
  input  logic [7:0]        byteData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              txMain,
  output logic              txAlt,
  output logic              txIrq,
  output logic              statBusy,
  output logic              statAborted
);

  txStrobeT strobe;
  logic     busy;
  logic     loopEn;
  logic     txBit;
  logic     lastBit;
  logic     byteReady;
  logic     bytesLeftZero;

  hdlc_tx_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .ctlWe        (ctlWe),
    .ctlEnable    (ctlEnable),
    .ctlAbort     (ctlAbort),
    .ctlReset     (ctlReset),
    .ctlLoop      (ctlLoop),
    .lastBit      (lastBit),
    .byteReady    (byteReady),
    .bytesLeftZero(bytesLeftZero),
    .strobe       (strobe),
    .busy         (busy),
    .aborted      (statAborted),
    .irq          (txIrq),
    .loopEn       (loopEn)
  );

  hdlc_tx_datapath #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .locked       (busy),
    .cfgAddrWe    (cfgAddrWe),
    .cfgAddrIn    (cfgAddrIn),
    .cfgLenWe     (cfgLenWe),
    .cfgLenIn     (cfgLenIn),
    .byteAck      (byteAck),
    .byteData     (byteData),
    .byteReq      (byteReq),
    .fetchAddr    (fetchAddr),
    .txBit        (txBit),
    .lastBit      (lastBit),
    .byteReady    (byteReady),
    .bytesLeftZero(bytesLeftZero)
  );

  assign statBusy = busy;
  assign txAlt    = txBit;
  assign txMain   = loopEn ? 1'b1 : txBit;

  assert_loop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && ctlLoop) |=> txMain);

endmodule

// File: tb/hdlc_tx_bench.sv
module hdlc_tx_bench;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgAddrWe = 1'b0;
  logic [ADDR_W-1:0] cfgAddrIn = '0;
  logic              cfgLenWe = 1'b0;
  logic [LEN_W-1:0]  cfgLenIn = '0;
  logic              ctlWe = 1'b0, ctlEnable = 1'b0, ctlAbort = 1'b0;
  logic              ctlReset = 1'b0, ctlLoop = 1'b0;
  logic              byteReq;
  logic              byteAck = 1'b0;
  logic [7:0]        byteData = '0;
  logic [ADDR_W-1:0] fetchAddr;
  logic              txMain, txAlt, txIrq, statBusy, statAborted;

  hdlc_tx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdlc_tx (
    .clk(clk), .rstN(rstN),
    .cfgAddrWe(cfgAddrWe), .cfgAddrIn(cfgAddrIn),
    .cfgLenWe(cfgLenWe), .cfgLenIn(cfgLenIn),
    .ctlWe(ctlWe), .ctlEnable(ctlEnable), .ctlAbort(ctlAbort),
    .ctlReset(ctlReset), .ctlLoop(ctlLoop),
    .byteReq(byteReq), .byteAck(byteAck), .byteData(byteData),
    .fetchAddr(fetchAddr), .txMain(txMain), .txAlt(txAlt),
    .txIrq(txIrq), .statBusy(statBusy), .statAborted(statAborted)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // byte source model
  logic [7:0]        mem [0:63];
  logic [ADDR_W-1:0] baseAddr = '0;
  int                respDelay = 2;
  int                reqCnt = 0;

  always @(negedge clk) begin
    if (rstN && byteReq) begin
      reqCnt = reqCnt + 1;
      if (reqCnt == respDelay) begin
        byteAck  = 1'b1;
        byteData = mem[6'(fetchAddr - baseAddr)];
        reqCnt   = 0;
      end else begin
        byteAck = 1'b0;
      end
    end else begin
      byteAck = 1'b0;
      reqCnt  = 0;
    end
  end

  // line decoder model
  int         ones = 0;
  bit         inFrame = 0;
  int         bitCnt = 0;
  int         flagCnt = 0, abortCnt = 0, frameCnt = 0, badCnt = 0;
  int         lastLen = 0;
  logic [7:0] rxBuf [0:79];
  logic [7:0] rxFrame [0:79];

  always @(negedge clk) begin
    if (rstN) begin
      if (txAlt) begin
        ones = ones + 1;
        if (ones == 7) begin
          abortCnt = abortCnt + 1;
          inFrame  = 0;
          bitCnt   = 0;
        end else if (ones < 7 && inFrame && bitCnt < 640) begin
          rxBuf[bitCnt >> 3][bitCnt & 7] = 1'b1;
          bitCnt = bitCnt + 1;
        end
      end else begin
        if (ones == 6) begin
          flagCnt = flagCnt + 1;
          if (inFrame && bitCnt - 7 > 0) begin
            if (((bitCnt - 7) % 8) == 0) begin
              frameCnt = frameCnt + 1;
              lastLen  = (bitCnt - 7) / 8;
              for (int i = 0; i < 80; i++) rxFrame[i] = rxBuf[i];
            end else begin
              badCnt = badCnt + 1;
            end
          end
          inFrame = 1;
          bitCnt  = 0;
        end else if (ones != 5 && inFrame && bitCnt < 640) begin
          rxBuf[bitCnt >> 3][bitCnt & 7] = 1'b0;
          bitCnt = bitCnt + 1;
        end
        ones = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expFcs(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = (c >> 1) ^ (((c[0] ^ mem[i][k]) != 1'b0) ? 16'h8408 : 16'h0000);
    return ~c;
  endfunction

  task automatic ctlWrite(input bit en, input bit ab, input bit rs, input bit lp);
    @(negedge clk);
    ctlWe = 1; ctlEnable = en; ctlAbort = ab; ctlReset = rs; ctlLoop = lp;
    @(negedge clk);
    ctlWe = 0; ctlEnable = 0; ctlAbort = 0; ctlReset = 0; ctlLoop = 0;
  endtask

  task automatic cfgWrite(input logic [ADDR_W-1:0] a, input int n);
    @(negedge clk);
    cfgAddrWe = 1; cfgAddrIn = a; cfgLenWe = 1; cfgLenIn = LEN_W'(n);
    @(negedge clk);
    cfgAddrWe = 0; cfgLenWe = 0;
  endtask

  task automatic waitIrq(input string tag);
    int t;
    t = 0;
    while (!txIrq && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(txIrq == 1'b1, tag, txIrq, 1);
    repeat (30) @(negedge clk);
  endtask

  task automatic fillMem(input int pat);
    for (int i = 0; i < 64; i++)
      case (pat)
        0: mem[i] = 8'(i * 37 + 11);
        1: mem[i] = 8'hFF;
        2: mem[i] = 8'h00;
        default: mem[i] = 8'(i ^ (i << 3) ^ 8'h5A);
      endcase
  endtask

  task automatic checkFrame(input int n, input int fBefore, input int aBefore);
    logic [15:0] f;
    bit          same;
    f = expFcs(n);
    check(frameCnt == fBefore + 1, "R4 one frame decoded", frameCnt - fBefore, 1);
    check(abortCnt == aBefore, "R2 no seven-ones run", abortCnt - aBefore, 0);
    check(lastLen == n + 2, "R4 frame length", lastLen, n + 2);
    same = 1;
    for (int i = 0; i < n; i++) if (rxFrame[i] !== mem[i]) same = 0;
    check(same, "R2 user bytes after destuffing", 0, 0);
    check({rxFrame[n + 1], rxFrame[n]} == f, "R3 check sequence",
          {rxFrame[n + 1], rxFrame[n]}, f);
    check(statBusy == 0 && statAborted == 0, "R7 status after frame",
          {statBusy, statAborted}, 0);
    check(fetchAddr == baseAddr + ADDR_W'(n), "R4 fetch address advanced",
          fetchAddr, baseAddr + ADDR_W'(n));
  endtask

  task automatic runFrame(input int n, input int d, input int pat);
    int fB, aB;
    fillMem(pat);
    respDelay = d;
    baseAddr  = ADDR_W'(16'h1200 + n * 3);
    ctlWrite(0, 0, 1, 0);
    check(txIrq == 0, "R8 reset clears irq", txIrq, 0);
    cfgWrite(baseAddr, n);
    fB = frameCnt; aB = abortCnt;
    ctlWrite(1, 0, 0, 0);
    check(statBusy == 1, "R4 enable accepted", statBusy, 1);
    waitIrq("R7 irq after frame");
    checkFrame(n, fB, aB);
  endtask

  initial begin
    int fB, aB, fl;
    bit ok;
    int zeros;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(txIrq == 0 && statBusy == 0 && statAborted == 0 && byteReq == 0,
          "R8 reset state", {txIrq, statBusy, statAborted, byteReq}, 0);
    check(fetchAddr == 0, "R8 reset address", fetchAddr, 0);
    repeat (40) @(negedge clk);
    fl = flagCnt;
    repeat (80) @(negedge clk);
    check(flagCnt - fl == 10, "R1 idle flags every 8 clocks", flagCnt - fl, 10);
    check(frameCnt == 0 && abortCnt == 0, "R1 nothing but flags", frameCnt + abortCnt, 0);

    // sweep of lengths, patterns and source latencies
    for (int n = 0; n <= 6; n++)
      for (int d = 1; d <= 3; d++)
        runFrame(n, d, (n + d) % 4);
    runFrame(20, 2, 1);
    runFrame(33, 1, 3);
    runFrame(0, 2, 0); // R11 empty frame: check sequence only
    check(rxFrame[0] == 8'h00 && rxFrame[1] == 8'h00, "R11 empty frame fcs",
          {rxFrame[1], rxFrame[0]}, 0);

    // R10 acknowledge in the boundary clock
    runFrame(4, 8, 2);

    // R5 acknowledge one clock late: underrun
    fillMem(2);
    respDelay = 9;
    ctlWrite(0, 0, 1, 0);
    cfgWrite(16'h0400, 4);
    fB = frameCnt; aB = abortCnt;
    ctlWrite(1, 0, 0, 0);
    waitIrq("R5 irq after underrun abort");
    check(abortCnt == aB + 1, "R5 abort sequence on line", abortCnt - aB, 1);
    check(frameCnt == fB, "R5 no valid frame", frameCnt - fB, 0);
    check(statAborted == 1 && statBusy == 0, "R5 aborted status",
          {statBusy, statAborted}, 1);

    // R6 host abort mid frame, then flags resume
    fillMem(0);
    respDelay = 2;
    ctlWrite(0, 0, 1, 0);
    check(statAborted == 0, "R8 reset clears aborted", statAborted, 0);
    cfgWrite(16'h0800, 30);
    fB = frameCnt; aB = abortCnt;
    ctlWrite(1, 0, 0, 0);
    repeat (70) @(negedge clk);
    ctlWrite(0, 1, 0, 0);
    waitIrq("R6 irq after host abort");
    check(abortCnt == aB + 1 && frameCnt == fB, "R6 abort replaces frame",
          abortCnt - aB, 1);
    check(statAborted == 1, "R6 aborted status", statAborted, 1);
    fl = flagCnt;
    repeat (40) @(negedge clk);
    check(flagCnt - fl == 5, "R6 flags resume", flagCnt - fl, 5);

    // R8 lockout while transmitting
    fillMem(3);
    baseAddr = 16'h2000;
    ctlWrite(0, 0, 1, 0);
    cfgWrite(baseAddr, 12);
    fB = frameCnt; aB = abortCnt;
    ctlWrite(1, 0, 0, 0);
    repeat (40) @(negedge clk);
    ctlWrite(0, 0, 1, 0);
    check(statBusy == 1, "R8 reset ignored while busy", statBusy, 1);
    cfgWrite(16'h3000, 3);
    ctlWrite(1, 0, 0, 0);
    waitIrq("R8 frame completes after ignored writes");
    checkFrame(12, fB, aB);
    check(txIrq == 1, "R7 irq held", txIrq, 1);
    ctlWrite(0, 0, 1, 0);
    check(fetchAddr == 0 && txIrq == 0 && statAborted == 0, "R8 reset clears registers",
          fetchAddr, 0);
    baseAddr = '0;
    fB = frameCnt;
    ctlWrite(1, 0, 0, 0);
    waitIrq("R8 count cleared gives empty frame");
    check(frameCnt == fB + 1 && lastLen == 2, "R8 count cleared", lastLen, 2);

    // R9 loopback
    ctlWrite(0, 0, 0, 1);
    ok = 1; zeros = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (txMain !== 1'b1) ok = 0;
      if (txAlt == 1'b0) zeros++;
    end
    check(ok, "R9 main output idle in loopback", txMain, 1);
    check(zeros > 0, "R9 secondary output carries flags", zeros, 12);
    ctlWrite(0, 0, 0, 0);
    ok = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (txMain !== txAlt) ok = 0;
    end
    check(ok, "R9 loopback cleared by control write", txMain, txAlt);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule